// File: doc/BRIEF.md
# Line-Blank Paced Block Copier

This engine copies memory in fixed chunks of sixteen bytes, moving one chunk each time the display enters its horizontal blanking gap. Software loads a 16-bit source and a 16-bit destination pointer, then writes a control byte. That control byte selects blank-paced operation and gives the number of chunks to move. After that, every horizontal-blank pulse that arrives while the scan is on a visible line (line number below 144) starts one chunk. The chunk copies its bytes over a single-port byte memory, one read followed by one write per byte. It holds the processor stalled for the whole chunk, plus a fixed tail of 8 clocks, or 16 clocks when the double-speed input is high. For scale, a display line lasts 456 clocks and a frame has 154 lines, so a frame is 70224 clocks and a chunk with its tail uses only a small part of one line.

The sequencer has five states:
- `ST_IDLE`: nothing pending.
- `ST_WAIT`: armed, waiting for a qualifying blank.
- `ST_READ`: read strobe on the source pointer.
- `ST_WRITE`: write strobe on the destination pointer.
- `ST_HOLD`: stall tail.

It has these transitions:
- arm (`ST_IDLE`→`ST_WAIT`) on a control write with the mode bit set.
- cancel (`ST_WAIT`→`ST_IDLE`) on a control write with the mode bit clear.
- launch (`ST_WAIT`→`ST_READ`) on a qualifying blank.
- fetch (`ST_READ`→`ST_WRITE`).
- next (`ST_WRITE`→`ST_READ`) while bytes remain in the chunk.
- close (`ST_WRITE`→`ST_HOLD`) after the sixteenth byte.
- rearm (`ST_HOLD`→`ST_WAIT`) when the tail ends and chunks remain.
- finish (`ST_HOLD`→`ST_IDLE`) when the tail ends and no chunks remain.

Top module: `hbdma_engine`

## Requirements
- R1: After reset the engine is idle: `cpu_stall`, `mem_rd` and `mem_wr` are low, and `stat_rdata` reads 0x7F.
- R2: A write to register index 4 (control) with bit 7 set loads the remaining chunk count as bits 6:0 plus one, and makes the engine active. `stat_rdata` then reads bit 7 = active and bits 6:0 = remaining chunks minus one.
- R3: A chunk starts in the cycle after a cycle with `hblank` high only if the engine is waiting, chunks remain, and `line_num` is below 144 (143 qualifies). Any other blank pulse has no effect.
- R4: A chunk is 16 byte moves. Each move is one cycle with `mem_rd` high and `mem_addr` equal to the source pointer, then one cycle with `mem_wr` high, `mem_addr` equal to the destination pointer and `mem_wdata` equal to `mem_rdata`. The memory returns read data in the cycle after `mem_rd`.
- R5: Both pointers advance by one after every byte. They carry over from one chunk to the next and wrap modulo 2^16.
- R6: Each completed chunk lowers the remaining count by one (16 bytes). When it reaches zero the engine goes idle, and `stat_rdata` bit 7 drops.
- R7: `cpu_stall` is high without a break from the first read cycle of a chunk for 32 + 8 cycles when `speed_dbl` is low, and for 32 + 16 cycles when it is high.
- R8: A control write with bit 7 clear while the engine is waiting cancels the transfer. Later blank pulses move nothing, and the status keeps the remaining count with bit 7 low.
- R9: A control write with bit 7 clear while the engine is idle has no effect.
- R10: All register writes made while a chunk is in progress (read, write or tail state) are ignored.
- R11: Register indices 0 and 1 load the high and low bytes of the source pointer. Indices 2 and 3 load the high and low bytes of the destination pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register index (0..4) |
| cfg_wdata | input | 8 | Register write data |
| stat_rdata | output | 8 | Status: bit 7 active, bits 6:0 remaining chunks minus one |
| hblank | input | 1 | Horizontal-blank event, one cycle |
| line_num | input | 8 | Current display line |
| speed_dbl | input | 1 | Double-speed mode, doubles the stall tail |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |
| cpu_stall | output | 1 | Processor hold request |

## Verification
A pointer that is off by one shows up at the first `mem_wr` of the chunk, as a wrong address or wrong data, within two cycles of the launch. A wrong chunk count does not show during the copy. It shows in `stat_rdata` one cycle after the close transition, or as an extra or missing chunk on the next blank. A tail counter fault shows up only as a stall that is too short or too long at its falling edge, so the bench measures every stall window and compares it with the length expected for the speed mode.

// File: rtl/hbdma_pkg.sv
package hbdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_HOLD  = 3'd4
    } hb_state_t;

    localparam logic [2:0] REG_SRC_HI = 3'd0;
    localparam logic [2:0] REG_SRC_LO = 3'd1;
    localparam logic [2:0] REG_DST_HI = 3'd2;
    localparam logic [2:0] REG_DST_LO = 3'd3;
    localparam logic [2:0] REG_CTRL   = 3'd4;

    localparam int CTRL_MODE_BIT = 7;
    localparam int CNT_FIELD_W   = 7;

endpackage

// File: rtl/hbdma_addr_ctr.sv
// Byte pointer: loadable per byte lane, post-incremented per byte moved.
module hbdma_addr_ctr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [7:0]        wdata,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - 8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end else begin
            if (ld_hi) addr[ADDR_W-1:8] <= wdata[HI_W-1:0];
            if (ld_lo) addr[7:0]        <= wdata;
        end
    end
endmodule

// File: rtl/hbdma_tail.sv
// Stall tail timer: loaded at chunk close, counts down while holding.
module hbdma_tail #(
    parameter int STALL_NORM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dbl,
    input  logic run,
    output logic done
);
    localparam int STALL_LONG = STALL_NORM * 2;
    localparam int CW         = $clog2(STALL_LONG);
    localparam logic [CW-1:0] NORM_M1 = CW'(STALL_NORM - 1);
    localparam logic [CW-1:0] LONG_M1 = CW'(STALL_LONG - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= dbl ? LONG_M1 : NORM_M1;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/hbdma_seq.sv
// Chunk sequencer: arming, launch qualification, byte stepping, chunk count.
module hbdma_seq
    import hbdma_pkg::*;
#(
    parameter int BURST_LEN = 16,
    parameter int LINE_W    = 8,
    parameter int VIS_LINES = 144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hblank,
    input  logic [LINE_W-1:0] line_num,
    input  logic              ctrl_we,
    input  logic [7:0]        ctrl_wdata,
    input  logic              tail_done,
    output hb_state_t         state,
    output logic              cfg_open,
    output logic              src_inc,
    output logic              dst_inc,
    output logic              chunk_close,
    output logic [CNT_FIELD_W:0] blk_left
);
    localparam int BC_W = $clog2(BURST_LEN);
    localparam logic [BC_W-1:0]   LAST_BYTE = BC_W'(BURST_LEN - 1);
    localparam logic [LINE_W-1:0] LINE_LIM  = LINE_W'(VIS_LINES);
    localparam int BLK_W = CNT_FIELD_W + 1;

    hb_state_t       nxt;
    logic [BC_W-1:0] bcnt;
    logic            mode_set;
    logic            launch;

    assign mode_set = ctrl_wdata[CTRL_MODE_BIT];
    assign launch   = (state == ST_WAIT) && !ctrl_we && hblank &&
                      (line_num < LINE_LIM) && (blk_left != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ctrl_we && mode_set) nxt = ST_WAIT;
            ST_WAIT: begin
                if (ctrl_we && !mode_set) nxt = ST_IDLE;
                else if (launch)          nxt = ST_READ;
            end
            ST_READ:  nxt = ST_WRITE;
            ST_WRITE: nxt = (bcnt == LAST_BYTE) ? ST_HOLD : ST_READ;
            ST_HOLD: begin
                if (tail_done) nxt = (blk_left != '0) ? ST_WAIT : ST_IDLE;
            end
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cfg_open    = 1'b0;
        src_inc     = 1'b0;
        dst_inc     = 1'b0;
        chunk_close = 1'b0;
        unique case (state)
            ST_IDLE, ST_WAIT: cfg_open = 1'b1;
            ST_READ:          src_inc  = 1'b1;
            ST_WRITE: begin
                dst_inc     = 1'b1;
                chunk_close = (bcnt == LAST_BYTE);
            end
            ST_HOLD:          ;
            default:          ;
        endcase
    end

    // byte index inside a chunk
    always_ff @(posedge clk) begin
        if (!rst_n)         bcnt <= '0;
        else if (launch)    bcnt <= '0;
        else if (dst_inc)   bcnt <= bcnt + 1'b1;
    end

    // remaining chunk count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_left <= '0;
        end else if (ctrl_we && cfg_open && mode_set) begin
            blk_left <= BLK_W'({1'b0, ctrl_wdata[CNT_FIELD_W-1:0]}) + 1'b1;
        end else if (chunk_close) begin
            blk_left <= blk_left - 1'b1;
        end
    end
endmodule

// File: rtl/hbdma_engine.sv
module hbdma_engine
    import hbdma_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LINE_W     = 8,
    parameter int VIS_LINES  = 144,
    parameter int BURST_LEN  = 16,
    parameter int STALL_NORM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        stat_rdata,
    input  logic              hblank,
    input  logic [LINE_W-1:0] line_num,
    input  logic              speed_dbl,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              cpu_stall
);
    hb_state_t         state;
    logic              cfg_open, src_inc, dst_inc, chunk_close, tail_done;
    logic [CNT_FIELD_W:0] blk_left;
    logic [CNT_FIELD_W:0] blk_m1;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic              wr_ok;

    assign wr_ok = cfg_we && cfg_open;

    hbdma_seq #(
        .BURST_LEN (BURST_LEN),
        .LINE_W    (LINE_W),
        .VIS_LINES (VIS_LINES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hblank      (hblank),
        .line_num    (line_num),
        .ctrl_we     (cfg_we && cfg_sel == REG_CTRL),
        .ctrl_wdata  (cfg_wdata),
        .tail_done   (tail_done),
        .state       (state),
        .cfg_open    (cfg_open),
        .src_inc     (src_inc),
        .dst_inc     (dst_inc),
        .chunk_close (chunk_close),
        .blk_left    (blk_left)
    );

    hbdma_addr_ctr #(.ADDR_W(ADDR_W)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_hi (wr_ok && cfg_sel == REG_SRC_HI),
        .ld_lo (wr_ok && cfg_sel == REG_SRC_LO),
        .wdata (cfg_wdata),
        .inc   (src_inc),
        .addr  (src_addr)
    );

    hbdma_addr_ctr #(.ADDR_W(ADDR_W)) u_dst (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_hi (wr_ok && cfg_sel == REG_DST_HI),
        .ld_lo (wr_ok && cfg_sel == REG_DST_LO),
        .wdata (cfg_wdata),
        .inc   (dst_inc),
        .addr  (dst_addr)
    );

    hbdma_tail #(.STALL_NORM(STALL_NORM)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .start (chunk_close),
        .dbl   (speed_dbl),
        .run   (state == ST_HOLD),
        .done  (tail_done)
    );

    // memory port and stall decode
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = src_addr;
        cpu_stall = 1'b0;
        unique case (state)
            ST_READ: begin
                mem_rd    = 1'b1;
                cpu_stall = 1'b1;
            end
            ST_WRITE: begin
                mem_wr    = 1'b1;
                mem_addr  = dst_addr;
                cpu_stall = 1'b1;
            end
            ST_HOLD:          cpu_stall = 1'b1;
            ST_IDLE, ST_WAIT: ;
            default:          ;
        endcase
    end

    assign mem_wdata  = mem_rdata;
    assign blk_m1     = blk_left - 1'b1;
    assign stat_rdata = {state != ST_IDLE, blk_m1[CNT_FIELD_W-1:0]};
endmodule

// File: rtl/hbdma_checker.sv
module hbdma_checker #(
    parameter int ADDR_W    = 16,
    parameter int LINE_W    = 8,
    parameter int VIS_LINES = 144
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hblank,
    input logic [LINE_W-1:0] line_num,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cpu_stall,
    input logic [7:0]        stat_rdata
);
    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r7_stall_covers_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> cpu_stall);

    a_r3_launch_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_stall) |-> (mem_rd && $past(hblank) &&
                              ($past(line_num) < LINE_W'(VIS_LINES))));

    a_r5_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd, 2)) |-> (mem_addr == $past(mem_addr, 2) + 1'b1));

    a_r5_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr, 2)) |-> (mem_addr == $past(mem_addr, 2) + 1'b1));

    a_r6_active_during_stall: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> stat_rdata[7]);
endmodule

bind hbdma_engine hbdma_checker #(
    .ADDR_W    (ADDR_W),
    .LINE_W    (LINE_W),
    .VIS_LINES (VIS_LINES)
) u_hbdma_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .hblank     (hblank),
    .line_num   (line_num),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_addr   (mem_addr),
    .cpu_stall  (cpu_stall),
    .stat_rdata (stat_rdata)
);

// File: tb/test_hbdma_engine.sv
module test_hbdma_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  stat_rdata;
    logic        hblank = 1'b0;
    logic [7:0]  line_num = '0;
    logic        speed_dbl = 1'b0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        cpu_stall;

    int checks = 0;
    int fails = 0;
    int writes_seen = 0;
    bit done = 1'b0;

    typedef struct packed { logic [15:0] addr; logic [7:0] data; } wr_item_t;
    wr_item_t wr_q[$];
    int       stall_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hbdma_engine i_hbdma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .stat_rdata(stat_rdata), .hblank(hblank),
        .line_num(line_num), .speed_dbl(speed_dbl), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .cpu_stall(cpu_stall)
    );

    function automatic logic [7:0] pattern(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    // memory model: data returned the cycle after a read strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= pattern(mem_addr);

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_blank(input logic [7:0] line);
        @(negedge clk);
        hblank = 1'b1; line_num = line;
        @(negedge clk);
        hblank = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: expected 16 writes of one chunk and its stall length
    task automatic expect_chunk(input logic [15:0] src, input logic [15:0] dst,
                                input int stall_len);
        for (int i = 0; i < 16; i++) begin
            wr_item_t it;
            it.addr = dst + 16'(i);
            it.data = pattern(src + 16'(i));
            wr_q.push_back(it);
        end
        stall_q.push_back(stall_len);
    endtask

    // monitor: writes (R4 address/data, R5 pointer stepping)
    always @(negedge clk) begin
        if (rst_n && mem_wr) begin
            writes_seen++;
            if (wr_q.size() == 0) begin
                check(1'b0, "R4 unexpected write", {16'h0, mem_addr}, 32'h0);
            end else begin
                wr_item_t e;
                e = wr_q.pop_front();
                check(mem_addr == e.addr, "R5 write address", {16'h0, mem_addr}, {16'h0, e.addr});
                check(mem_wdata == e.data, "R4 write data", {24'h0, mem_wdata}, {24'h0, e.data});
            end
        end
    end

    // monitor: stall window length (R7)
    int stall_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_stall) begin
                stall_run++;
            end else if (stall_run != 0) begin
                if (stall_q.size() == 0) begin
                    check(1'b0, "R7 unexpected stall", stall_run, 0);
                end else begin
                    int e;
                    e = stall_q.pop_front();
                    check(stall_run == e, "R7 stall length", stall_run, e);
                end
                stall_run = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int w0;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        // R1 reset state
        check(!cpu_stall && !mem_rd && !mem_wr, "R1 strobes idle",
              {cpu_stall, mem_rd, mem_wr}, 0);
        check(stat_rdata == 8'h7F, "R1 status", stat_rdata, 8'h7F);

        // R11 pointers, R2 arm with 3 chunks
        write_reg(3'd0, 8'h12); write_reg(3'd1, 8'h34);
        write_reg(3'd2, 8'h80); write_reg(3'd3, 8'h00);
        write_reg(3'd4, 8'h82);
        check(stat_rdata == 8'h82, "R2 armed status", stat_rdata, 8'h82);

        // R3 blank on invisible line: no effect
        w0 = writes_seen;
        pulse_blank(8'd150);
        wait_cycles(50);
        check(writes_seen == w0, "R3 line 150 ignored", writes_seen - w0, 0);
        check(stat_rdata == 8'h82, "R3 status unchanged", stat_rdata, 8'h82);

        // R3 boundary line 143, R11 pointer values, R7 normal stall
        expect_chunk(16'h1234, 16'h8000, 40);
        pulse_blank(8'd143);
        wait_cycles(50);
        check(stat_rdata == 8'h81, "R6 count after chunk 1", stat_rdata, 8'h81);
        check(wr_q.size() == 0, "R4 chunk 1 complete", wr_q.size(), 0);

        // R7 double speed; R10 writes during chunk ignored; R5 carry-over
        speed_dbl = 1'b1;
        expect_chunk(16'h1244, 16'h8010, 48);
        pulse_blank(8'd0);
        write_reg(3'd0, 8'hFF);
        write_reg(3'd4, 8'h00);
        wait_cycles(60);
        check(stat_rdata == 8'h80, "R10 control write in chunk ignored", stat_rdata, 8'h80);

        // last chunk: R10 source write ignored shows in addresses, R6 goes idle
        speed_dbl = 1'b0;
        expect_chunk(16'h1254, 16'h8020, 40);
        pulse_blank(8'd10);
        wait_cycles(50);
        check(stat_rdata == 8'h7F, "R6 idle after last chunk", stat_rdata, 8'h7F);

        // R6 no chunk after exhaustion
        w0 = writes_seen;
        pulse_blank(8'd20);
        wait_cycles(50);
        check(writes_seen == w0, "R6 no chunk when idle", writes_seen - w0, 0);

        // R9 mode-clear write while idle
        write_reg(3'd4, 8'h05);
        check(stat_rdata == 8'h7F, "R9 idle control write ignored", stat_rdata, 8'h7F);
        w0 = writes_seen;
        pulse_blank(8'd5);
        wait_cycles(50);
        check(writes_seen == w0, "R9 still no transfer", writes_seen - w0, 0);

        // R8 cancel while waiting
        write_reg(3'd4, 8'h83);
        check(stat_rdata == 8'h83, "R2 rearm status", stat_rdata, 8'h83);
        write_reg(3'd4, 8'h00);
        check(stat_rdata == 8'h03, "R8 cancelled status", stat_rdata, 8'h03);
        w0 = writes_seen;
        pulse_blank(8'd5);
        wait_cycles(50);
        check(writes_seen == w0, "R8 no transfer after cancel", writes_seen - w0, 0);

        // R5 wrap of both pointers
        write_reg(3'd0, 8'hFF); write_reg(3'd1, 8'hF8);
        write_reg(3'd2, 8'hFF); write_reg(3'd3, 8'hFC);
        write_reg(3'd4, 8'h80);
        check(stat_rdata == 8'h80, "R2 single chunk status", stat_rdata, 8'h80);
        expect_chunk(16'hFFF8, 16'hFFFC, 40);
        pulse_blank(8'd100);
        wait_cycles(50);
        check(stat_rdata == 8'h7F, "R6 idle after wrap chunk", stat_rdata, 8'h7F);
        check(wr_q.size() == 0, "R5 all wrapped writes seen", wr_q.size(), 0);
        check(stall_q.size() == 0, "R7 all stall windows seen", stall_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule